// File: doc/BRIEF.md
# Active Priority Level Register

This block records which of eight interrupt priority levels are in service at any moment. Level 0 is the most urgent and level 7 the least. A level becomes active when the interrupt scanner grants a break on it, or when software raises the running routine to a more urgent level. A debreak command ends the most urgent active level, so control falls back to the next active level below it.

From the active set and a global enable, the block drives a mask that tells the scanner which levels may still interrupt. It also evaluates a conditional-skip test. The test is true when any condition chosen in a select word holds. The conditions are "the system is enabled" and "this level and every more urgent level are idle". A status port shows the enable flag and the eight active bits.

All commands are single-cycle pulses. They are sampled on the rising clock edge. Their effect shows on the outputs after that edge.

Top module: `prio_level_reg`

## Requirements
- R1: A synchronous active-high reset clears all eight active bits and the enable flag. After reset, `status` is 0 and `allow_mask` is 0.
- R2: When `en_wr` is high, the enable flag takes the value of `en_val` on the next edge. Otherwise the flag holds its value.
- R3: When `grant_vld` is high, the active bit whose index is `grant_lvl` is set on the next edge. Other active bits are not disturbed by the grant.
- R4: When `raise_vld` is high, bit N of `raise_req` asks for level N. Only the lowest-index set bit is considered. That level is set only if its index is lower than the index of every active bit. Otherwise the request has no effect. An accepted raise clears no other active bit.
- R5: When `dbk` is high, only the lowest-index active bit is cleared. With no active bit, a debreak changes nothing.
- R6: When commands arrive in the same cycle, the debreak clear is applied first. Grant and raise bits are then ORed in. A raise is judged against the active set as it stood at the start of that cycle.
- R7: `allow_mask` bit L is 1 only when the enable flag is 1 and every active bit with index L or lower is 0. A disabled block drives an all-zero mask.
- R8: `skip_hit` is the OR of the selected conditions. `skip_sel` bit 8 selects "enable flag is 1". Bit N (0 to 7) selects "active bits 0 through N are all 0". An all-zero select gives 0.
- R9: `status` bit 8 is the enable flag and bits 7:0 are the active bits, with bit N for level N. Both come straight from the state registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable flag |
| en_val | input | 1 | New enable value |
| grant_vld | input | 1 | Scanner granted a break |
| grant_lvl | input | 3 | Level of the granted break |
| raise_vld | input | 1 | Software raise-priority request |
| raise_req | input | 8 | One bit per requested level, bit N = level N |
| dbk | input | 1 | Debreak: release the most urgent active level |
| skip_sel | input | 9 | Skip-test condition select |
| allow_mask | output | 8 | Levels allowed to interrupt, bit N = level N |
| skip_hit | output | 1 | Skip-test result |
| status | output | 9 | {enable, active[7:0]} |

## Verification
Grant, raise, debreak and enable writes each take effect one rising edge after they are presented. The bench therefore drives each command on a falling edge and reads `status` and `allow_mask` at the following falling edge, after exactly one rising edge. `skip_hit` is combinational from `skip_sel` and the stored state, so skip selects are changed with no clock edge in between and read a short delay later. Same-cycle combinations, such as a debreak with a grant or a debreak with a raise, are checked against the state the bench expects before and after that one edge.

// File: rtl/prio_lvl_pkg.sv
package prio_lvl_pkg;

    parameter int NUM_LVL = 8;
    localparam int LVL_W  = $clog2(NUM_LVL);
    localparam int SEL_W  = NUM_LVL + 1;

    typedef logic [NUM_LVL-1:0] lvl_vec_t;
    typedef logic [LVL_W-1:0]   lvl_idx_t;

    // enable sits above the active bits so the packed struct is the status word
    typedef struct packed {
        logic     en;
        lvl_vec_t act;
    } lvl_state_t;

    // isolates the most urgent (lowest index) set bit
    function automatic lvl_vec_t lowest_bit(lvl_vec_t v);
        return v & (~v + lvl_vec_t'(1));
    endfunction

    // bit i is set when any of v[0..i] is set
    function automatic lvl_vec_t prefix_any(lvl_vec_t v);
        lvl_vec_t r;
        r[0] = v[0];
        for (int i = 1; i < NUM_LVL; i++) begin
            r[i] = r[i-1] | v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/prio_lvl_state.sv
module prio_lvl_state
    import prio_lvl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr,
    input  logic       en_val,
    input  logic       grant_vld,
    input  lvl_idx_t   grant_lvl,
    input  logic       raise_vld,
    input  lvl_vec_t   raise_req,
    input  logic       dbk,
    output lvl_state_t st_q
);

    lvl_state_t st_d;
    lvl_vec_t   after_dbk;
    lvl_vec_t   grant_set;
    lvl_vec_t   raise_pick;
    lvl_vec_t   raise_set;

    always_comb begin
        after_dbk  = dbk ? (st_q.act & ~lowest_bit(st_q.act)) : st_q.act;
        grant_set  = grant_vld ? (lvl_vec_t'(1) << grant_lvl) : '0;
        raise_pick = raise_vld ? lowest_bit(raise_req) : '0;
        // accepted only if no active bit sits at or above the picked level
        raise_set  = ((raise_pick & prefix_any(st_q.act)) == '0) ? raise_pick : '0;
        st_d.act   = after_dbk | grant_set | raise_set;
        st_d.en    = en_wr ? en_val : st_q.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/prio_lvl_mask.sv
module prio_lvl_mask
    import prio_lvl_pkg::*;
(
    input  lvl_state_t st,
    output lvl_vec_t   quiet,
    output lvl_vec_t   allow_mask
);

    // quiet[i]: levels 0..i all idle, built as a ripple chain
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_quiet
        if (i == 0) begin : g_first
            assign quiet[i] = ~st.act[i];
        end else begin : g_next
            assign quiet[i] = quiet[i-1] & ~st.act[i];
        end
    end

    assign allow_mask = st.en ? quiet : '0;

endmodule

// File: rtl/prio_lvl_skip.sv
module prio_lvl_skip
    import prio_lvl_pkg::*;
(
    input  logic             en,
    input  lvl_vec_t         quiet,
    input  logic [SEL_W-1:0] skip_sel,
    output logic             skip_hit
);

    assign skip_hit = (skip_sel[NUM_LVL] & en) | (|(skip_sel[NUM_LVL-1:0] & quiet));

endmodule

// File: rtl/prio_level_reg.sv
module prio_level_reg
    import prio_lvl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             grant_vld,
    input  logic [LVL_W-1:0] grant_lvl,
    input  logic             raise_vld,
    input  logic [NUM_LVL-1:0] raise_req,
    input  logic             dbk,
    input  logic [SEL_W-1:0] skip_sel,
    output logic [NUM_LVL-1:0] allow_mask,
    output logic             skip_hit,
    output logic [SEL_W-1:0] status
);

    lvl_state_t st_q;
    lvl_vec_t   quiet;

    prio_lvl_state u_state (
        .clk       (clk),
        .rst       (rst),
        .en_wr     (en_wr),
        .en_val    (en_val),
        .grant_vld (grant_vld),
        .grant_lvl (grant_lvl),
        .raise_vld (raise_vld),
        .raise_req (raise_req),
        .dbk       (dbk),
        .st_q      (st_q)
    );

    prio_lvl_mask u_mask (
        .st         (st_q),
        .quiet      (quiet),
        .allow_mask (allow_mask)
    );

    prio_lvl_skip u_skip (
        .en       (st_q.en),
        .quiet    (quiet),
        .skip_sel (skip_sel),
        .skip_hit (skip_hit)
    );

    assign status = st_q;

endmodule

// File: rtl/prio_level_reg_chk.sv
module prio_level_reg_chk
    import prio_lvl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             grant_vld,
    input logic [LVL_W-1:0] grant_lvl,
    input logic             raise_vld,
    input logic             dbk,
    input logic             en_wr,
    input logic [NUM_LVL-1:0] allow_mask,
    input logic [SEL_W-1:0] status
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (status == '0 && allow_mask == '0));

    // R3
    grant_sets_chk: assert property (@(posedge clk) disable iff (rst)
        grant_vld |=> status[$past(grant_lvl)]);

    // R5
    dbk_single_chk: assert property (@(posedge clk) disable iff (rst)
        (dbk && !grant_vld && !raise_vld && status[NUM_LVL-1:0] != '0)
        |=> ($countones(status[NUM_LVL-1:0]) ==
             $countones($past(status[NUM_LVL-1:0])) - 1));

    // R4
    raise_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (raise_vld && !dbk && !grant_vld)
        |=> ((status[NUM_LVL-1:0] & $past(status[NUM_LVL-1:0])) ==
             $past(status[NUM_LVL-1:0])));

    // R4
    raise_one_chk: assert property (@(posedge clk) disable iff (rst)
        (raise_vld && !dbk && !grant_vld)
        |=> ($countones(status[NUM_LVL-1:0]) <=
             $countones($past(status[NUM_LVL-1:0])) + 1));

    // R7
    mask_below_chk: assert property (@(posedge clk) disable iff (rst)
        (status[NUM_LVL-1:0] != '0) |->
        ((allow_mask & ~(lowest_bit(status[NUM_LVL-1:0]) - lvl_vec_t'(1))) == '0));

    // R7
    mask_off_chk: assert property (@(posedge clk) disable iff (rst)
        !status[NUM_LVL] |-> (allow_mask == '0));

    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(status[NUM_LVL]));

endmodule

bind prio_level_reg prio_level_reg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .grant_vld  (grant_vld),
    .grant_lvl  (grant_lvl),
    .raise_vld  (raise_vld),
    .dbk        (dbk),
    .en_wr      (en_wr),
    .allow_mask (allow_mask),
    .status     (status)
);

// File: tb/prio_level_reg_tb.sv
`timescale 1ns/1ps
module prio_level_reg_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_wr = 1'b0, en_val = 1'b0;
    logic       grant_vld = 1'b0;
    logic [2:0] grant_lvl = '0;
    logic       raise_vld = 1'b0;
    logic [7:0] raise_req = '0;
    logic       dbk = 1'b0;
    logic [8:0] skip_sel = '0;
    logic [7:0] allow_mask;
    logic       skip_hit;
    logic [8:0] status;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    prio_level_reg u_dut (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_val(en_val),
        .grant_vld(grant_vld), .grant_lvl(grant_lvl),
        .raise_vld(raise_vld), .raise_req(raise_req), .dbk(dbk),
        .skip_sel(skip_sel), .allow_mask(allow_mask),
        .skip_hit(skip_hit), .status(status)
    );

    // {en_wr, en_val, grant_vld, grant_lvl[2:0], raise_vld, raise_req[7:0], dbk, exp_act[7:0], exp_mask[7:0]}
    localparam int N_VEC = 20;
    localparam logic [31:0] VEC [N_VEC] = '{
        {1'b1,1'b1,1'b0,3'd0,1'b0,8'h00,1'b0,8'h00,8'hFF}, // R2 enable
        {1'b0,1'b0,1'b1,3'd5,1'b0,8'h00,1'b0,8'h20,8'h1F}, // R3 grant 5
        {1'b0,1'b0,1'b1,3'd2,1'b0,8'h00,1'b0,8'h24,8'h03}, // R3 grant 2
        {1'b0,1'b0,1'b0,3'd0,1'b1,8'h40,1'b0,8'h24,8'h03}, // R4 lower ignored
        {1'b0,1'b0,1'b0,3'd0,1'b1,8'h04,1'b0,8'h24,8'h03}, // R4 equal ignored
        {1'b0,1'b0,1'b0,3'd0,1'b1,8'h01,1'b0,8'h25,8'h00}, // R4 raise to 0
        {1'b0,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1,8'h24,8'h03}, // R5 dbk
        {1'b0,1'b0,1'b1,3'd1,1'b0,8'h00,1'b1,8'h22,8'h01}, // R6 dbk+grant
        {1'b0,1'b0,1'b0,3'd0,1'b1,8'h81,1'b0,8'h23,8'h00}, // R4 two bits, lowest wins
        {1'b0,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1,8'h22,8'h01}, // R5
        {1'b0,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1,8'h20,8'h1F}, // R5
        {1'b0,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1,8'h00,8'hFF}, // R5
        {1'b0,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1,8'h00,8'hFF}, // R5 empty dbk
        {1'b0,1'b0,1'b0,3'd0,1'b1,8'h08,1'b0,8'h08,8'h07}, // R4 from idle
        {1'b1,1'b0,1'b0,3'd0,1'b0,8'h00,1'b0,8'h08,8'h00}, // R7 disabled mask
        {1'b0,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1,8'h00,8'h00}, // R7
        {1'b1,1'b1,1'b0,3'd0,1'b0,8'h00,1'b0,8'h00,8'hFF}, // R2 re-enable
        {1'b0,1'b0,1'b1,3'd2,1'b0,8'h00,1'b0,8'h04,8'h03}, // R3
        {1'b0,1'b0,1'b0,3'd0,1'b1,8'h08,1'b1,8'h00,8'hFF}, // R6 raise judged on old state
        {1'b0,1'b0,1'b1,3'd6,1'b1,8'h08,1'b0,8'h48,8'h07}  // R6 grant+raise
    };

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        en_wr = 0; en_val = 0; grant_vld = 0; grant_lvl = '0;
        raise_vld = 0; raise_req = '0; dbk = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        skip_sel = 9'h100;
        #1;
        check("R1 status after reset", status, 0);
        check("R1 mask after reset", allow_mask, 0);
        check("R8 enable test while disabled", skip_hit, 0);

        for (int i = 0; i < N_VEC; i++) begin
            @(negedge clk);
            {en_wr, en_val, grant_vld, grant_lvl, raise_vld, raise_req, dbk} = VEC[i][31:16];
            @(negedge clk);
            idle_inputs();
            check($sformatf("R3-R7 vec %0d active", i), status[7:0], VEC[i][15:8]);
            check($sformatf("R7 vec %0d mask", i), allow_mask, VEC[i][7:0]);
        end

        // active = levels 3 and 6, enabled
        check("R9 status word", status, 9'h148);
        skip_sel = 9'h004; #1;
        check("R8 level2 and higher idle", skip_hit, 1);
        skip_sel = 9'h008; #1;
        check("R8 level3 and higher idle", skip_hit, 0);
        skip_sel = 9'h0F8; #1;
        check("R8 levels 3..7 selected", skip_hit, 0);
        skip_sel = 9'h100; #1;
        check("R8 enable test", skip_hit, 1);
        skip_sel = 9'h000; #1;
        check("R8 empty select", skip_hit, 0);

        // mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        skip_sel = 9'h100; #1;
        check("R1 status after mid reset", status, 0);
        check("R1 mask after mid reset", allow_mask, 0);
        check("R8 enable test after reset", skip_hit, 0);
        skip_sel = 9'h080; #1;
        check("R8 all idle after reset", skip_hit, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule